// File: doc/BRIEF.md
# Lock Progress Monitor Controller

This block supervises the lock sequence of a digital bang-bang frequency synthesizer loop. After a frequency-change command it holds the loop in a wide-gain acquisition mode with a linear phase comparison. It watches the quantized phase error on every reference strobe. Once two successive phase-error samples differ by at most one LSB, it moves the loop into tracking mode, where the phase comparison is binary.

In tracking mode it stops looking at the phase error and studies the ripple on the loop-filter integrator output instead. A slope-sign reversal between successive integrator samples marks a local peak or trough, and the block holds the latest of each. Every reversal that finds both a peak and a trough on hand yields an estimate of the settled integrator value: their mean, rounded down. When enough consecutive estimates agree within a programmable window, the loop is near lock. From then on each further in-window estimate lowers the proportional and integral gain codes by one step. Once both codes have reached their programmed floors, the loop is reported locked.

All decisions are taken on the reference strobe edge and appear on the registered outputs one clock later. The filter datapath that consumes the mode and gain codes lies outside this block.

Top module: `lockmon_ctrl`

## Requirements
- R1: Reset or `retune_i` puts the block in acquisition: `status_o` = 0, `track_mode_o` = 0, `kp_sel_o` = KP_INIT (5) and `ki_sel_o` = KI_INIT (6), one clock after the command.
- R2: In acquisition, a strobe whose phase error differs from the previous strobe's phase error by -1, 0 or +1 moves the block to wide tracking (`status_o` = 1, `track_mode_o` = 1). A larger difference, or the first strobe after R1, leaves it in acquisition.
- R3: In tracking states, a reversal is a strobe whose integrator sample moves opposite to the last non-zero slope. The previous sample is then a peak (rising to falling) or a trough (falling to rising). Equal successive samples neither reverse nor change the remembered slope.
- R4: At each reversal the new extremum is held as the latest peak or trough. If the opposite extremum is already held, an estimate floor((peak + trough) / 2) is produced.
- R5: An estimate compared with the previous estimate is in-window when their absolute difference is at most `win_i`. When such a comparison makes `hits_i` consecutive in-window comparisons, wide tracking moves to stepping (`status_o` = 2) with the gain codes unchanged.
- R6: An out-of-window comparison clears the consecutive in-window count to zero. The count saturates at its maximum.
- R7: In stepping, each in-window comparison lowers each gain code by one, but only while that code is above its floor (`kp_floor_i`, `ki_floor_i`). Gain codes change at no other time except R1.
- R8: When a step leaves both codes at or below their floors, the block enters locked (`status_o` = 3). It stays there until R1.
- R9: `retune_i` takes priority over a strobe in the same cycle.
- R10: With `ref_stb_i` low, the phase error and integrator inputs have no effect on any output or on later decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| retune_i | input | 1 | frequency-change command, restarts acquisition |
| ref_stb_i | input | 1 | reference strobe, one cycle per reference period |
| phase_err_i | input | PE_W | signed quantized phase error |
| integ_i | input | INT_W | signed integrator output of the loop filter |
| win_i | input | INT_W | lock window on estimate differences |
| hits_i | input | CNT_W | consecutive in-window comparisons needed for near-lock |
| kp_floor_i | input | G_W | proportional gain code floor |
| ki_floor_i | input | G_W | integral gain code floor |
| track_mode_o | output | 1 | 0 acquisition (linear detect), 1 tracking (binary detect) |
| kp_sel_o | output | G_W | proportional gain select code |
| ki_sel_o | output | G_W | integral gain select code |
| status_o | output | 2 | 0 acquire, 1 tracking wide, 2 stepping, 3 locked |

## Verification
Every result of a strobe is due on the registered outputs at the clock edge that samples the strobe. This covers the mode change, near-lock, each gain step and lock. The bench therefore raises the strobe after a falling edge and compares all four outputs at the next falling edge against a per-strobe arithmetic model. Between strobes it leaves one clock with deliberately altered phase-error and integrator values and the strobe low. Any sampling of those values would show up as a mismatch at the next comparison. A retune, alone or together with a strobe, is checked one clock later in the same way.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;
  typedef enum logic [1:0] {
    ST_ACQ  = 2'd0,
    ST_WIDE = 2'd1,
    ST_STEP = 2'd2,
    ST_LOCK = 2'd3
  } lm_state_e;
endpackage

// File: rtl/lockmon_slope.sv
// Slope reversal detector on strobed integrator samples.
module lockmon_slope #(
  parameter int INT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    stb,
  input  logic signed [INT_W-1:0] sample_i,
  output logic                    rev_o,
  output logic                    is_peak_o,
  output logic signed [INT_W-1:0] ext_o
);
  logic signed [INT_W-1:0] prev_q;
  logic prev_v_q, dir_up_q, dir_v_q;
  logic rising, falling;

  always_comb begin
    rising    = prev_v_q && (sample_i > prev_q);
    falling   = prev_v_q && (sample_i < prev_q);
    rev_o     = stb && dir_v_q && ((rising && !dir_up_q) || (falling && dir_up_q));
    is_peak_o = rev_o && dir_up_q;
  end

  assign ext_o = prev_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_q   <= '0;
      prev_v_q <= 1'b0;
      dir_up_q <= 1'b0;
      dir_v_q  <= 1'b0;
    end else if (stb) begin
      prev_q   <= sample_i;
      prev_v_q <= 1'b1;
      if (rising || falling) begin
        dir_up_q <= rising;
        dir_v_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockmon_hold.sv
// Peak and trough hold registers with floor-mean estimate.
module lockmon_hold #(
  parameter int INT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    rev_i,
  input  logic                    is_peak_i,
  input  logic signed [INT_W-1:0] ext_i,
  output logic                    est_v_o,
  output logic signed [INT_W-1:0] est_o
);
  logic signed [INT_W-1:0] peak_q, trough_q, other;
  logic peak_v_q, trough_v_q, other_v;
  logic signed [INT_W:0] sum;

  always_comb begin
    other   = is_peak_i ? trough_q   : peak_q;
    other_v = is_peak_i ? trough_v_q : peak_v_q;
    sum     = {ext_i[INT_W-1], ext_i} + {other[INT_W-1], other};
    est_o   = sum[INT_W:1];
    est_v_o = rev_i && other_v;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      peak_q     <= '0;
      trough_q   <= '0;
      peak_v_q   <= 1'b0;
      trough_v_q <= 1'b0;
    end else if (rev_i) begin
      if (is_peak_i) begin
        peak_q   <= ext_i;
        peak_v_q <= 1'b1;
      end else begin
        trough_q   <= ext_i;
        trough_v_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockmon_window.sv
// Consecutive in-window estimate qualifier.
module lockmon_window #(
  parameter int INT_W = 12,
  parameter int CNT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    est_v_i,
  input  logic signed [INT_W-1:0] est_i,
  input  logic        [INT_W-1:0] win_i,
  input  logic        [CNT_W-1:0] hits_i,
  output logic                    qual_o,
  output logic                    near_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic signed [INT_W-1:0] last_q;
  logic last_v_q;
  logic [CNT_W-1:0] cnt_q;
  logic signed [INT_W:0] diff;
  logic [INT_W:0] mag;
  logic [CNT_W:0] cnt_inc;
  logic in_win;

  always_comb begin
    diff    = {est_i[INT_W-1], est_i} - {last_q[INT_W-1], last_q};
    mag     = diff[INT_W] ? $unsigned(-diff) : $unsigned(diff);
    in_win  = mag <= {1'b0, win_i};
    cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
    qual_o  = est_v_i && last_v_q && in_win;
    near_o  = qual_o && (cnt_inc >= {1'b0, hits_i});
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      last_q   <= '0;
      last_v_q <= 1'b0;
      cnt_q    <= '0;
    end else if (est_v_i) begin
      last_q   <= est_i;
      last_v_q <= 1'b1;
      if (last_v_q) begin
        if (!in_win)              cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_inc[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/lockmon_gain.sv
// One gain select code: loads its initial value, steps down to a floor.
module lockmon_gain #(
  parameter int G_W  = 3,
  parameter int INIT = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [G_W-1:0] floor_i,
  output logic [G_W-1:0] code_o,
  output logic           floor_next_o
);
  localparam logic [G_W-1:0] INIT_CODE = G_W'(INIT);

  logic [G_W-1:0] code_q, code_nxt;

  always_comb begin
    code_nxt     = (code_q > floor_i) ? code_q - G_W'(1) : code_q;
    floor_next_o = code_nxt <= floor_i;
  end

  always_ff @(posedge clk) begin
    if (rst || load) code_q <= INIT_CODE;
    else if (step)   code_q <= code_nxt;
  end

  assign code_o = code_q;
endmodule

// File: rtl/lockmon_ctrl.sv
module lockmon_ctrl
  import lockmon_pkg::*;
#(
  parameter int INT_W   = 12,
  parameter int PE_W    = 8,
  parameter int CNT_W   = 4,
  parameter int G_W     = 3,
  parameter int KP_INIT = 5,
  parameter int KI_INIT = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    retune_i,
  input  logic                    ref_stb_i,
  input  logic signed [PE_W-1:0]  phase_err_i,
  input  logic signed [INT_W-1:0] integ_i,
  input  logic        [INT_W-1:0] win_i,
  input  logic        [CNT_W-1:0] hits_i,
  input  logic        [G_W-1:0]   kp_floor_i,
  input  logic        [G_W-1:0]   ki_floor_i,
  output logic                    track_mode_o,
  output logic        [G_W-1:0]   kp_sel_o,
  output logic        [G_W-1:0]   ki_sel_o,
  output logic        [1:0]       status_o
);
  lm_state_e state_q;
  logic signed [PE_W-1:0] pe_last_q;
  logic pe_v_q;
  logic signed [PE_W:0] pe_diff;
  logic settled, advance, rip_clr, step_go;
  logic rev, is_peak, est_v, qual, near;
  logic signed [INT_W-1:0] ext, est;
  logic kp_fn, ki_fn;

  assign advance = ref_stb_i && !retune_i;
  assign rip_clr = retune_i || (state_q == ST_ACQ);
  assign step_go = advance && (state_q == ST_STEP) && qual;

  always_comb begin
    pe_diff = {phase_err_i[PE_W-1], phase_err_i} - {pe_last_q[PE_W-1], pe_last_q};
    settled = pe_v_q && ((pe_diff == '0) || (pe_diff == (PE_W+1)'(1)) || (pe_diff == '1));
  end

  lockmon_slope #(.INT_W(INT_W)) u_slope (
    .clk(clk), .rst(rst), .clr(rip_clr), .stb(ref_stb_i), .sample_i(integ_i),
    .rev_o(rev), .is_peak_o(is_peak), .ext_o(ext));

  lockmon_hold #(.INT_W(INT_W)) u_hold (
    .clk(clk), .rst(rst), .clr(rip_clr), .rev_i(rev), .is_peak_i(is_peak),
    .ext_i(ext), .est_v_o(est_v), .est_o(est));

  lockmon_window #(.INT_W(INT_W), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .clr(rip_clr), .est_v_i(est_v), .est_i(est),
    .win_i(win_i), .hits_i(hits_i), .qual_o(qual), .near_o(near));

  lockmon_gain #(.G_W(G_W), .INIT(KP_INIT)) u_kp (
    .clk(clk), .rst(rst), .load(retune_i), .step(step_go), .floor_i(kp_floor_i),
    .code_o(kp_sel_o), .floor_next_o(kp_fn));

  lockmon_gain #(.G_W(G_W), .INIT(KI_INIT)) u_ki (
    .clk(clk), .rst(rst), .load(retune_i), .step(step_go), .floor_i(ki_floor_i),
    .code_o(ki_sel_o), .floor_next_o(ki_fn));

  always_ff @(posedge clk) begin
    if (rst || retune_i) begin
      state_q   <= ST_ACQ;
      pe_last_q <= '0;
      pe_v_q    <= 1'b0;
    end else if (ref_stb_i) begin
      unique case (state_q)
        ST_ACQ: begin
          pe_last_q <= phase_err_i;
          pe_v_q    <= 1'b1;
          if (settled) state_q <= ST_WIDE;
        end
        ST_WIDE: if (near) state_q <= ST_STEP;
        ST_STEP: if (qual && kp_fn && ki_fn) state_q <= ST_LOCK;
        default: state_q <= ST_LOCK;
      endcase
    end
  end

  assign track_mode_o = (state_q != ST_ACQ);
  assign status_o     = state_q;
endmodule

// File: rtl/lockmon_chk.sv
module lockmon_chk #(
  parameter int G_W     = 3,
  parameter int KP_INIT = 5,
  parameter int KI_INIT = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           retune_i,
  input logic           ref_stb_i,
  input logic [G_W-1:0] kp_floor_i,
  input logic [G_W-1:0] ki_floor_i,
  input logic           track_mode_o,
  input logic [G_W-1:0] kp_sel_o,
  input logic [G_W-1:0] ki_sel_o,
  input logic [1:0]     status_o
);
  // R1
  retune_init_chk: assert property (@(posedge clk) disable iff (rst)
    retune_i |=> (status_o == 2'd0 && !track_mode_o &&
                  kp_sel_o == G_W'(KP_INIT) && ki_sel_o == G_W'(KI_INIT)));

  // R10
  strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o != $past(status_o)) |-> ($past(ref_stb_i) || $past(retune_i)));

  // R7
  kp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (kp_sel_o < $past(kp_sel_o)) |->
      (kp_sel_o >= kp_floor_i && kp_sel_o == $past(kp_sel_o) - G_W'(1)));

  // R7
  ki_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ki_sel_o < $past(ki_sel_o)) |->
      (ki_sel_o >= ki_floor_i && ki_sel_o == $past(ki_sel_o) - G_W'(1)));

  // R7
  gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (((kp_sel_o != $past(kp_sel_o)) || (ki_sel_o != $past(ki_sel_o))) && !$past(retune_i))
      |-> ($past(status_o) == 2'd2));

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(status_o) == 2'd3 && !$past(retune_i)) |-> (status_o == 2'd3));
endmodule

bind lockmon_ctrl lockmon_chk #(.G_W(G_W), .KP_INIT(KP_INIT), .KI_INIT(KI_INIT)) u_chk (
  .clk(clk), .rst(rst), .retune_i(retune_i), .ref_stb_i(ref_stb_i),
  .kp_floor_i(kp_floor_i), .ki_floor_i(ki_floor_i), .track_mode_o(track_mode_o),
  .kp_sel_o(kp_sel_o), .ki_sel_o(ki_sel_o), .status_o(status_o));

// File: tb/lockmon_ctrl_test.sv
`timescale 1ns/1ps
module lockmon_ctrl_test;
  localparam int INT_W = 12, PE_W = 8, CNT_W = 4, G_W = 3;
  localparam int KP0 = 5, KI0 = 6;

  logic clk = 1'b0, rst = 1'b1, retune = 1'b0, stb = 1'b0;
  logic signed [PE_W-1:0]  pe_in = '0;
  logic signed [INT_W-1:0] ig_in = '0;
  logic [INT_W-1:0] win = '0;
  logic [CNT_W-1:0] hits = '0;
  logic [G_W-1:0] kpf = '0, kif = '0;
  logic track;
  logic [G_W-1:0] kp, ki;
  logic [1:0] status;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  int m_state, m_kp, m_ki, m_pe_last, m_pe_v;
  int s_prev, s_pv, s_up, s_dv, pk, pk_v, tr, tr_v, ep, ep_v, cnt;
  int c_win, c_hits, c_kpf, c_kif;

  always #4 clk = ~clk;

  lockmon_ctrl #(.INT_W(INT_W), .PE_W(PE_W), .CNT_W(CNT_W), .G_W(G_W),
                 .KP_INIT(KP0), .KI_INIT(KI0)) uut (
    .clk(clk), .rst(rst), .retune_i(retune), .ref_stb_i(stb),
    .phase_err_i(pe_in), .integ_i(ig_in), .win_i(win), .hits_i(hits),
    .kp_floor_i(kpf), .ki_floor_i(kif), .track_mode_o(track),
    .kp_sel_o(kp), .ki_sel_o(ki), .status_o(status));

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " status"}, int'(status), m_state);
    chk("R2 track_mode", int'(track), (m_state != 0) ? 1 : 0);
    chk("R7 kp_sel", int'(kp), m_kp);
    chk("R7 ki_sel", int'(ki), m_ki);
  endtask

  task automatic m_clear_rip();
    s_pv = 0; s_dv = 0; s_up = 0; pk_v = 0; tr_v = 0; ep_v = 0; cnt = 0;
  endtask

  task automatic m_retune();
    m_state = 0; m_kp = KP0; m_ki = KI0; m_pe_v = 0;
    m_clear_rip();
  endtask

  task automatic m_strobe(input int pe, input int ig);
    int ext, other, ov, est, rising, falling, rev, peak, estv, qual, near, inw;
    if (m_state == 0) begin
      inw = m_pe_v && (iabs(pe - m_pe_last) <= 1);
      m_pe_last = pe; m_pe_v = 1;
      m_clear_rip();
      if (inw) m_state = 1;
    end else begin
      ext = s_prev;
      rising  = s_pv && (ig > s_prev);
      falling = s_pv && (ig < s_prev);
      rev  = s_dv && ((rising && !s_up) || (falling && s_up));
      peak = rev && s_up;
      s_prev = ig; s_pv = 1;
      if (rising || falling) begin s_up = rising; s_dv = 1; end
      estv = 0; qual = 0; near = 0; est = 0;
      if (rev) begin
        if (peak) begin other = tr; ov = tr_v; pk = ext; pk_v = 1; end
        else      begin other = pk; ov = pk_v; tr = ext; tr_v = 1; end
        if (ov) begin estv = 1; est = (ext + other) >>> 1; end
      end
      if (estv) begin
        if (ep_v) begin
          inw  = iabs(est - ep) <= c_win;
          qual = inw;
          near = inw && (cnt + 1 >= c_hits);
          cnt  = inw ? ((cnt < 15) ? cnt + 1 : 15) : 0;
        end
        ep = est; ep_v = 1;
      end
      if (m_state == 1 && near) m_state = 2;
      else if (m_state == 2 && qual) begin
        if (m_kp > c_kpf) m_kp--;
        if (m_ki > c_kif) m_ki--;
        if (m_kp <= c_kpf && m_ki <= c_kif) m_state = 3;
      end
    end
  endtask

  // strobe at a falling edge, compare one clock later, then leave junk inputs for a cycle
  task automatic strobe(input int pe, input int ig, input string tag);
    @(negedge clk);
    pe_in = PE_W'(pe); ig_in = INT_W'(ig); stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    m_strobe(pe, ig);
    compare(tag);
    pe_in = PE_W'(pe + 1); ig_in = INT_W'(ig ^ 1365);
  endtask

  task automatic do_retune(input bit with_stb);
    @(negedge clk);
    retune = 1'b1; stb = with_stb; pe_in = '0; ig_in = INT_W'(7);
    @(negedge clk);
    retune = 1'b0; stb = 1'b0;
    m_retune();
    compare(with_stb ? "R9" : "R1");
  endtask

  function automatic int wave(input int w, input int k);
    int t;
    case (k % 4)
      1: t = 6;
      3: t = -6;
      default: t = 0;
    endcase
    if (w <= 3) return 100 + t + w * (k / 2);
    if (w == 4) return 100 + t + ((k >= 16) ? 9 : 0);
    case (k % 6)
      1, 2: t = 6;
      4, 5: t = -6;
      default: t = 0;
    endcase
    return 100 + t;
  endfunction

  task automatic run(input int w, input int h, input int wn, input int fl);
    string tag;
    c_win = wn; c_hits = h;
    c_kpf = fl ? 7 : 3; c_kif = fl ? 7 : 2;
    win = INT_W'(wn); hits = CNT_W'(h); kpf = G_W'(c_kpf); kif = G_W'(c_kif);
    do_retune(h == 2);
    strobe(20, 0, "R2");
    strobe(10, 0, "R2");
    strobe(fl ? 11 : 9, 0, "R2");
    for (int k = 0; k < 40; k++) begin
      if (w == 5)      tag = "R3";
      else if (w == 4) tag = "R6";
      else case (m_state)
        0: tag = "R2";
        1: tag = "R4/R5";
        2: tag = "R6/R7";
        default: tag = "R8";
      endcase
      strobe(k * 13 - 60, wave(w, k), tag);
    end
  endtask

  initial begin
    m_retune();
    c_win = 0; c_hits = 0; c_kpf = 0; c_kif = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1");
    // R10: phase error one LSB away from the last strobe, presented with strobe low
    strobe(5, 0, "R2");
    pe_in = PE_W'(6);
    repeat (3) @(negedge clk);
    chk("R10 status with strobe low", int'(status), 0);
    strobe(9, 0, "R2");   // diff 4
    strobe(7, 0, "R2");   // diff -2
    strobe(6, 0, "R2");   // diff -1: leaves acquisition
    for (int w = 0; w < 6; w++)
      for (int h = 1; h < 4; h++)
        for (int wn = 0; wn < 4; wn++)
          for (int fl = 0; fl < 2; fl++)
            run(w, h, wn, fl);
    do_retune(1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog got=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule